// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a two-part logical address, a segment number and an offset within that segment, into a physical address. It uses a segment table that sits in ordinary memory. The caller presents a request over a valid/ready handshake. A request carries the segment number, the offset and an access kind (read, write or execute). The table's starting address and its entry count come in as two register inputs. The unit samples them when it accepts the request.

The unit first checks the segment number against the table length. A number outside the table ends the request at once, with no memory traffic. Otherwise the unit fetches the two-word table entry through a single read port. Word 0 is the segment base. Word 1 packs the segment length with four flag bits: present, read, write and execute. The unit then checks the entry and answers with a one-cycle response. The response carries either a physical address (base plus offset) or a trap with a numeric cause.

Only one request is in flight at a time. Table entries are not cached, so every in-range request costs two memory reads.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_o` are 0.
- R2: If the segment number is not below `tbl_len_i`, the response traps with cause 1 and no memory read is issued. This includes the case where `tbl_len_i` is 0.
- R3: For an in-range segment s, the unit reads address `tbl_base_i + 2*s` (base word) and then `tbl_base_i + 2*s + 1` (attribute word). It reads both words before it reports any result. While `mem_req_o` is high and `mem_rvalid_i` is low, `mem_addr_o` holds steady.
- R4: If bit 31 (present) of the attribute word is 0, the response traps with cause 2.
- R5: If the offset is greater than or equal to bits 23:0 of the attribute word (the limit), the response traps with cause 3. An offset of limit-1 is legal.
- R6: Access kind 0 (read) needs bit 30 of the attribute word. Kind 1 (write) needs bit 29, and kind 2 (execute) needs bit 28. Kind 3 is always refused. A refused access traps with cause 4.
- R7: A legal access responds with trap 0, cause 0 and a physical address equal to the base word plus the zero-extended offset, modulo 2^32.
- R8: `req_ready_o` drops in the cycle after acceptance and stays low until the response. `rsp_valid_o` is high for exactly one cycle per request.
- R9: When several checks fail, the reported cause is the lowest-numbered one (range, then present, then limit, then permission).
- R10: A trapping response drives `rsp_paddr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle and able to accept |
| req_seg_i | input | 8 | Segment number |
| req_off_i | input | 24 | Offset within segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_base_i | input | 32 | Word address of segment table |
| tbl_len_i | input | 9 | Number of table entries |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 32 | Read word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_trap_o | output | 1 | Response is a trap |
| rsp_cause_o | output | 3 | Trap cause (0 when no trap) |
| rsp_paddr_o | output | 32 | Physical address (0 on trap) |

## Verification
Several properties are checked on every cycle by assertions:
- an out-of-range reply never comes after a memory read, and every other reply comes after exactly two reads;
- the read address holds steady while the read is stalled;
- the response lasts a single cycle and acceptance is blocked while busy;
- trap replies carry a zero address.

Other behaviour shows only in the bench's scenarios:
- the entry addresses actually read;
- the cause ordering when several checks fail;
- offsets exactly at and one below the limit;
- each access kind against each flag;
- address wrap;
- reads with varying memory latency.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_RANGE   = 3'd1,
    CAUSE_INVALID = 3'd2,
    CAUSE_LIMIT   = 3'd3,
    CAUSE_PERM    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_FETCH_BASE,
    XS_FETCH_ATTR,
    XS_REPLY
  } xl_state_e;

  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic ex;
  } seg_flags_t;

  function automatic logic acc_allowed(acc_e acc, seg_flags_t f);
    case (acc)
      ACC_READ:  return f.rd;
      ACC_WRITE: return f.wr;
      ACC_EXEC:  return f.ex;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seg_xlate_attr_dec.sv
module seg_xlate_attr_dec
  import seg_xlate_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 24
) (
  input  logic [DW-1:0]    attr_word_i,
  output seg_flags_t       flags_o,
  output logic [OFF_W-1:0] limit_o
);
  // flags occupy the top four bits, present first
  localparam int FLAG_LSB = DW - 4;

  assign flags_o = seg_flags_t'(attr_word_i[DW-1:FLAG_LSB]);
  assign limit_o = attr_word_i[OFF_W-1:0];
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 24,
  parameter int DW    = 32
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W:0]   len_i,
  output logic             in_range_o,
  input  logic [DW-1:0]    base_word_i,
  input  logic [DW-1:0]    attr_word_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_e             acc_i,
  output cause_e           cause_o,
  output logic [DW-1:0]    paddr_o
);
  seg_flags_t       flags;
  logic [OFF_W-1:0] limit;

  seg_xlate_attr_dec #(.DW(DW), .OFF_W(OFF_W)) u_attr_dec (
    .attr_word_i(attr_word_i),
    .flags_o    (flags),
    .limit_o    (limit)
  );

  assign in_range_o = {1'b0, seg_i} < len_i;

  always_comb begin
    if (!flags.present)              cause_o = CAUSE_INVALID;
    else if (off_i >= limit)         cause_o = CAUSE_LIMIT;
    else if (!acc_allowed(acc_i, flags)) cause_o = CAUSE_PERM;
    else                             cause_o = CAUSE_NONE;
  end

  assign paddr_o = (cause_o == CAUSE_NONE) ? base_word_i + DW'(off_i) : '0;
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  output logic          accept_o,
  input  logic          in_range_i,
  input  logic [AW-1:0] entry_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] base_word_o,
  input  cause_e        cause_i,
  input  logic [DW-1:0] paddr_i,
  output logic          rsp_valid_o,
  output cause_e        rsp_cause_o,
  output logic [DW-1:0] rsp_paddr_o
);
  xl_state_e     state_q, state_d;
  logic [DW-1:0] base_word_q;
  cause_e        cause_q;
  logic [DW-1:0] paddr_q;
  logic [1:0]    rd_cnt_q;
  logic          rd_done;

  assign req_ready_o = (state_q == XS_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign mem_req_o   = (state_q == XS_FETCH_BASE) || (state_q == XS_FETCH_ATTR);
  assign mem_addr_o  = entry_addr_i + AW'(state_q == XS_FETCH_ATTR);
  assign rd_done     = mem_req_o && mem_rvalid_i;
  assign base_word_o = base_word_q;
  assign rsp_valid_o = (state_q == XS_REPLY);
  assign rsp_cause_o = cause_q;
  assign rsp_paddr_o = paddr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:       if (accept_o) state_d = in_range_i ? XS_FETCH_BASE : XS_REPLY;
      XS_FETCH_BASE: if (mem_rvalid_i) state_d = XS_FETCH_ATTR;
      XS_FETCH_ATTR: if (mem_rvalid_i) state_d = XS_REPLY;
      default:       state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= XS_IDLE;
      base_word_q <= '0;
      cause_q     <= CAUSE_NONE;
      paddr_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o && !in_range_i) begin
        cause_q <= CAUSE_RANGE;
        paddr_q <= '0;
      end
      if (state_q == XS_FETCH_BASE && mem_rvalid_i) base_word_q <= mem_rdata_i;
      // attribute word is checked as it arrives
      if (state_q == XS_FETCH_ATTR && mem_rvalid_i) begin
        cause_q <= cause_i;
        paddr_q <= paddr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rd_cnt_q <= '0;
    else if (accept_o)               rd_cnt_q <= '0;
    else if (rd_done && rd_cnt_q != 2'd3) rd_cnt_q <= rd_cnt_q + 2'd1;
  end

  AST_RANGE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cause_o == CAUSE_RANGE |-> rd_cnt_q == 2'd0); // R2
  AST_BOTH_WORDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cause_o != CAUSE_RANGE |-> rd_cnt_q == 2'd2); // R3
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R8
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R8
  AST_NO_READ_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o); // R8
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 24,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [SEG_W:0]   tbl_len_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_trap_o,
  output logic [2:0]       rsp_cause_o,
  output logic [DW-1:0]    rsp_paddr_o
);
  localparam int ENTRY_SHIFT = 1; // two words per entry

  logic             accept, in_range;
  logic [AW-1:0]    entry_q;
  logic [OFF_W-1:0] off_q;
  acc_e             acc_q;
  logic [DW-1:0]    base_word, chk_paddr;
  cause_e           chk_cause, rsp_cause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
      off_q   <= '0;
      acc_q   <= ACC_READ;
    end else if (accept) begin
      entry_q <= tbl_base_i + (AW'(req_seg_i) << ENTRY_SHIFT);
      off_q   <= req_off_i;
      acc_q   <= acc_e'(req_acc_i);
    end
  end

  seg_xlate_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .DW(DW)) u_check (
    .seg_i      (req_seg_i),
    .len_i      (tbl_len_i),
    .in_range_o (in_range),
    .base_word_i(base_word),
    .attr_word_i(mem_rdata_i),
    .off_i      (off_q),
    .acc_i      (acc_q),
    .cause_o    (chk_cause),
    .paddr_o    (chk_paddr)
  );

  seg_xlate_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .in_range_i  (in_range),
    .entry_addr_i(entry_q),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .base_word_o (base_word),
    .cause_i     (chk_cause),
    .paddr_i     (chk_paddr),
    .rsp_valid_o (rsp_valid_o),
    .rsp_cause_o (rsp_cause),
    .rsp_paddr_o (rsp_paddr_o)
  );

  assign rsp_cause_o = rsp_cause;
  assign rsp_trap_o  = (rsp_cause != CAUSE_NONE);

  AST_TRAP_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_trap_o |-> rsp_paddr_o == '0); // R10
  AST_CAUSE_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_cause_o <= 3'd4); // R9
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_seg = '0;
  logic [23:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic [31:0] tbl_base = '0;
  logic [8:0]  tbl_len = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rsp_valid, rsp_trap;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr;

  always #4 clk = ~clk; // 125 MHz

  seg_xlate u_seg_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_seg_i(req_seg), .req_off_i(req_off), .req_acc_i(req_acc),
    .tbl_base_i(tbl_base), .tbl_len_i(tbl_len),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_trap_o(rsp_trap),
    .rsp_cause_o(rsp_cause), .rsp_paddr_o(rsp_paddr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] mem [0:63];
  int          lat = 0;
  int          lat_cnt;
  int          rd_total;
  logic [31:0] rd_log [0:127];

  // memory model: responds after lat extra cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lat_cnt    <= 0;
      rd_total   <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && !mem_rvalid) begin
        if (lat_cnt >= lat) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[5:0]];
          rd_log[rd_total[6:0]] <= mem_addr;
          rd_total   <= rd_total + 1;
          lat_cnt    <= 0;
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  typedef struct packed {
    logic [2:0]  cause;
    logic [31:0] paddr;
    logic [1:0]  nreads;
    logic [31:0] a0;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic set_entry(input int tbase, input int idx, input logic [31:0] b,
                           input logic [23:0] lim, input logic v, input logic r,
                           input logic w, input logic x);
    mem[(tbase + 2*idx) % 64]     = b;
    mem[(tbase + 2*idx + 1) % 64] = {v, r, w, x, 4'h0, lim};
  endtask

  function automatic exp_t model(input logic [7:0] seg, input logic [23:0] off,
                                 input logic [1:0] acc);
    exp_t e;
    logic [31:0] w0, w1;
    logic ok;
    e = '0;
    if ({1'b0, seg} >= tbl_len) begin
      e.cause = 3'd1;
      return e;
    end
    e.nreads = 2'd2;
    e.a0 = tbl_base + {23'd0, seg, 1'b0};
    w0 = mem[e.a0[5:0]];
    w1 = mem[6'(e.a0[5:0] + 6'd1)];
    case (acc)
      2'd0: ok = w1[30];
      2'd1: ok = w1[29];
      2'd2: ok = w1[28];
      default: ok = 1'b0;
    endcase
    if (!w1[31])             e.cause = 3'd2;
    else if (off >= w1[23:0]) e.cause = 3'd3;
    else if (!ok)            e.cause = 3'd4;
    else                     e.paddr = w0 + {8'd0, off};
    return e;
  endfunction

  task automatic send(input logic [7:0] seg, input logic [23:0] off,
                      input logic [1:0] acc, input string tag);
    exp_q.push_back(model(seg, off, acc));
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_seg = seg;
    req_off = off;
    req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", "ready after accept", 64'(req_ready), 64'd0);
  endtask

  // monitor / scoreboard
  initial begin
    int  seen;
    bit  prev;
    seen = 0;
    prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev) chk(rsp_valid == 1'b0, "R8", "response pulse width", 64'(rsp_valid), 64'd0);
        prev = rsp_valid;
        if (rsp_valid) begin
          exp_t  e;
          string t;
          int    n;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected response", 64'(rsp_cause), 64'd0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n = rd_total - seen;
            chk(rsp_cause == e.cause, t, "cause", 64'(rsp_cause), 64'(e.cause));
            chk(rsp_trap == (e.cause != 3'd0), t, "trap", 64'(rsp_trap), 64'(e.cause != 3'd0));
            chk(rsp_paddr == e.paddr, (e.cause != 0) ? "R10" : t, "paddr", 64'(rsp_paddr), 64'(e.paddr));
            chk(n == int'(e.nreads), (e.nreads == 0) ? "R2" : "R3", "read count", 64'(n), 64'(e.nreads));
            if (n == 2 && e.nreads == 2) begin
              chk(rd_log[seen[6:0]] == e.a0, "R3", "base word addr",
                  64'(rd_log[seen[6:0]]), 64'(e.a0));
              chk(rd_log[7'(seen + 1)] == e.a0 + 32'd1, "R3", "attr word addr",
                  64'(rd_log[7'(seen + 1)]), 64'(e.a0 + 32'd1));
            end
          end
          seen = rd_total;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    set_entry(16, 0, 32'h1000_0000, 24'h100,    1, 1, 0, 1);
    set_entry(16, 1, 32'h2000_0000, 24'h040,    1, 1, 1, 0);
    set_entry(16, 2, 32'h3000_0000, 24'h010,    0, 1, 1, 1);
    set_entry(16, 3, 32'hFFFF_FF00, 24'h200,    1, 1, 1, 0);
    set_entry(16, 4, 32'h4000_0000, 24'h000,    1, 1, 1, 1);
    set_entry(16, 5, 32'h5000_0000, 24'hFFFFFF, 1, 0, 0, 0);
    set_entry(16, 6, 32'h6000_0000, 24'h000,    0, 0, 0, 0);
    set_entry(16, 7, 32'h7000_0000, 24'h020,    1, 0, 0, 1);
    set_entry(40, 0, 32'h0000_0300, 24'h080,    1, 1, 1, 1);
    tbl_base = 32'd16;
    tbl_len  = 9'd8;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_req == 1'b0, "R1", "reset mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    lat = 0; send(8'd0, 24'h10, 2'd0, "R7");
    lat = 1; send(8'd0, 24'hFF, 2'd2, "R5");  // limit-1 legal
    send(8'd0, 24'h100, 2'd0, "R5");          // offset == limit
    send(8'd0, 24'h20, 2'd1, "R6");           // write refused
    lat = 2; send(8'd1, 24'h3F, 2'd1, "R7");
    send(8'd1, 24'h0, 2'd2, "R6");            // exec refused
    send(8'd1, 24'h5, 2'd3, "R6");            // reserved kind
    lat = 3; send(8'd2, 24'h0, 2'd0, "R4");
    send(8'd3, 24'h150, 2'd0, "R7");          // wraps to 0x50
    lat = 0; send(8'd4, 24'h0, 2'd0, "R5");
    send(8'd5, 24'h123456, 2'd0, "R6");
    send(8'd6, 24'h5, 2'd1, "R9");            // invalid + limit + perm
    send(8'd7, 24'h30, 2'd0, "R9");           // limit + perm
    send(8'd7, 24'h1F, 2'd2, "R7");
    send(8'd8, 24'h0, 2'd0, "R2");            // seg == len
    send(8'd255, 24'h0, 2'd0, "R2");
    tbl_len = 9'd0;
    send(8'd0, 24'h0, 2'd0, "R2");
    tbl_base = 32'd40; tbl_len = 9'd1;
    lat = 1; send(8'd0, 24'h7F, 2'd1, "R3");
    send(8'd1, 24'h0, 2'd0, "R2");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule